// File: doc/BRIEF.md
# Parameterized Funnel Shifter Unit

This block is a purely combinational shifter for a WIDTH-bit operand. It covers six kinds of move: zero-filling shifts toward either end, the sign-extending right shift with its left counterpart, and circular rotation in both directions. The shift distance can be anything from zero to WIDTH-1. Every kind of move goes through the same datapath.

A small pre-stage builds a source word of 2*WIDTH-1 bits. The operand sits at one end of this word and a fill pattern, chosen by the operation, sits at the other. A window offset is also formed. Right moves use the shift amount as the offset. Left moves use WIDTH-1 minus the amount, which a subtractor produces. A cascade of log2(WIDTH) stages of 2-to-1 multiplexers then slides the source word by that offset. Each stage is steered by one offset bit, and the low WIDTH bits become the result.

The data interface carries no valid/ready handshake. The result follows the inputs within the same evaluation, and there is no back-pressure to honour. A surrounding pipeline registers the inputs and the result as its own timing needs.

Top module: `funnel_shifter_unit`

## Requirements
- R1: Operation code 000 (logical left) returns the operand moved toward the MSB by `shamt` positions, with zeros entering at bit 0.
- R2: Operation code 001 (logical right) returns the operand moved toward the LSB by `shamt` positions, with zeros entering at bit WIDTH-1.
- R3: Operation code 010 (arithmetic left) produces exactly the same result as code 000 for every operand and amount.
- R4: Operation code 011 (arithmetic right) moves the operand toward the LSB by `shamt` positions and fills the vacated upper bits with copies of operand bit WIDTH-1.
- R5: Operation code 100 (rotate left) gives result bit i = operand bit (i - shamt) mod WIDTH, so that no bit is lost.
- R6: Operation code 101 (rotate right) gives result bit i = operand bit (i + shamt) mod WIDTH.
- R7: With `shamt` equal to zero, the result equals the operand for every operation code.
- R8: Operation codes 110 and 111 return the operand unchanged, whatever the value of `shamt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | WIDTH | Operand to be moved |
| shamt | input | $clog2(WIDTH) | Shift or rotate distance, 0 to WIDTH-1 |
| op_sel | input | 3 | Operation code, encoded as in R1 to R8 |
| res_y | output | WIDTH | Shifted or rotated result |

## Verification
The block holds no state, so an internal fault can only appear as a wrong mapping from inputs to result, and it does so in the same evaluation as the stimulus. The faults that matter are these:
- A miswired multiplexer stage corrupts every case in which its offset bit is set.
- A wrong fill pattern corrupts only the bits that are vacated, so it shows only at nonzero distances.
- A wrong left offset breaks the zero-distance identity.

Sweeping all six operations, every distance and every 8-bit operand exposes each of these faults directly at `res_y`.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

  typedef enum logic [2:0] {
    OP_SHL_LOG = 3'b000,
    OP_SHR_LOG = 3'b001,
    OP_SHL_ARI = 3'b010,
    OP_SHR_ARI = 3'b011,
    OP_ROT_L   = 3'b100,
    OP_ROT_R   = 3'b101
  } shop_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } fill_e;

  typedef struct packed {
    logic  known;
    logic  to_left;
    fill_e fill;
  } shctl_t;

  function automatic shctl_t decode_op(input logic [2:0] code);
    shctl_t c;
    c.known   = 1'b1;
    c.to_left = 1'b0;
    c.fill    = FILL_ZERO;
    case (code)
      OP_SHL_LOG, OP_SHL_ARI: c.to_left = 1'b1;
      OP_SHR_LOG:             c.to_left = 1'b0;
      OP_SHR_ARI:             c.fill    = FILL_SIGN;
      OP_ROT_L: begin
        c.to_left = 1'b1;
        c.fill    = FILL_WRAP;
      end
      OP_ROT_R:               c.fill    = FILL_WRAP;
      default:                c.known   = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fsh_offset.sv
module fsh_offset #(
  parameter int WIDTH = 8,
  localparam int LG = $clog2(WIDTH)
) (
  input  funnel_pkg::shctl_t ctl,
  input  logic [LG-1:0]      amount,
  output logic [LG-1:0]      offset
);
  localparam logic [LG-1:0] TOP_IDX = LG'(WIDTH - 1);

  logic [LG-1:0] left_off;

  // The source word keeps the operand in its top WIDTH bits for left moves.
  assign left_off = TOP_IDX - amount;

  always_comb begin
    if (!ctl.known)       offset = '0;
    else if (ctl.to_left) offset = left_off;
    else                  offset = amount;
  end
endmodule

// File: rtl/fsh_source.sv
module fsh_source #(
  parameter int WIDTH = 8,
  localparam int SW = 2 * WIDTH - 1
) (
  input  funnel_pkg::shctl_t ctl,
  input  logic [WIDTH-1:0]   operand,
  output logic [SW-1:0]      src_word
);
  import funnel_pkg::*;

  logic [WIDTH-2:0] low_fill;
  logic [WIDTH-2:0] high_fill;

  always_comb begin
    low_fill = (ctl.fill == FILL_WRAP) ? operand[WIDTH-1:1] : '0;
    case (ctl.fill)
      FILL_SIGN: high_fill = {(WIDTH-1){operand[WIDTH-1]}};
      FILL_WRAP: high_fill = operand[WIDTH-2:0];
      default:   high_fill = '0;
    endcase
  end

  always_comb begin
    if (ctl.known && ctl.to_left) src_word = {operand, low_fill};
    else                          src_word = {high_fill, operand};
  end
endmodule

// File: rtl/fsh_window.sv
module fsh_window #(
  parameter int WIDTH = 8,
  localparam int LG = $clog2(WIDTH),
  localparam int SW = 2 * WIDTH - 1
) (
  input  logic [SW-1:0]    src_word,
  input  logic [LG-1:0]    offset,
  output logic [WIDTH-1:0] window
);
  logic [SW-1:0] stage [LG+1];

  assign stage[0] = src_word;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = offset[s] ? (stage[s] >> STEP) : stage[s];
  end

  assign window = stage[LG][WIDTH-1:0];
endmodule

// File: rtl/funnel_shifter_unit.sv
module funnel_shifter_unit #(
  parameter int WIDTH = 8,
  localparam int LG = $clog2(WIDTH),
  localparam int SW = 2 * WIDTH - 1
) (
  input  logic [WIDTH-1:0] src_a,
  input  logic [LG-1:0]    shamt,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] res_y
);
  import funnel_pkg::*;

  shctl_t        ctl;
  logic [LG-1:0] offset;
  logic [SW-1:0] src_word;

  assign ctl = decode_op(op_sel);

  fsh_offset #(.WIDTH(WIDTH)) u_offset (
    .ctl    (ctl),
    .amount (shamt),
    .offset (offset)
  );

  fsh_source #(.WIDTH(WIDTH)) u_source (
    .ctl      (ctl),
    .operand  (src_a),
    .src_word (src_word)
  );

  fsh_window #(.WIDTH(WIDTH)) u_window (
    .src_word (src_word),
    .offset   (offset),
    .window   (res_y)
  );

  always_comb begin
    if (shamt == '0)
      p_zero_amount_r7: assert (res_y == src_a) else $error("zero amount altered operand");
    if (op_sel[2:1] == 2'b11)
      p_unused_pass_r8: assert (res_y == src_a) else $error("unused code altered operand");
    if (op_sel == 3'b000 && shamt != '0)
      p_lsl_low_zero_r1: assert (res_y[0] == 1'b0) else $error("left shift bit0 not zero");
    if (op_sel == 3'b001 && shamt != '0)
      p_lsr_top_zero_r2: assert (res_y[WIDTH-1] == 1'b0) else $error("right shift msb not zero");
    if (op_sel == 3'b010 && shamt != '0)
      p_asl_low_zero_r3: assert (res_y[0] == 1'b0) else $error("arith left bit0 not zero");
    if (op_sel == 3'b011)
      p_asr_sign_r4: assert (res_y[WIDTH-1] == src_a[WIDTH-1]) else $error("arith right lost sign");
    if (op_sel == 3'b100)
      p_rol_count_r5: assert ($countones(res_y) == $countones(src_a)) else $error("rotate left lost bits");
    if (op_sel == 3'b101)
      p_ror_count_r6: assert ($countones(res_y) == $countones(src_a)) else $error("rotate right lost bits");
  end
endmodule

// File: tb/funnel_shifter_unit_bench.sv
module funnel_shifter_unit_bench;
  localparam int WIDTH = 8;
  localparam int LG = $clog2(WIDTH);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic [WIDTH-1:0] src_a = '0;
  logic [LG-1:0]    shamt = '0;
  logic [2:0]       op_sel = 3'b000;
  logic [WIDTH-1:0] res_y;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  funnel_shifter_unit #(.WIDTH(WIDTH)) u_funnel_shifter_unit (
    .src_a (src_a),
    .shamt (shamt),
    .op_sel(op_sel),
    .res_y (res_y)
  );

  function automatic logic [WIDTH-1:0] model(input logic [2:0] op, input logic [WIDTH-1:0] a,
                                             input int k);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      case (op)
        3'b000, 3'b010: r[i] = (i - k >= 0) ? a[i-k] : 1'b0;
        3'b001:         r[i] = (i + k < WIDTH) ? a[i+k] : 1'b0;
        3'b011:         r[i] = (i + k < WIDTH) ? a[i+k] : a[WIDTH-1];
        3'b100:         r[i] = a[(i - k + WIDTH) % WIDTH];
        3'b101:         r[i] = a[(i + k) % WIDTH];
        default:        r[i] = a[i];
      endcase
    end
    return r;
  endfunction

  task automatic apply_check(input string req, input logic [2:0] op,
                             input logic [WIDTH-1:0] a, input int k,
                             input logic [WIDTH-1:0] expv);
    @(posedge clk);
    op_sel = op;
    src_a  = a;
    shamt  = LG'(k);
    @(negedge clk);
    checks++;
    if (res_y !== expv) begin
      errors++;
      $display("FAIL %s op=%b a=%h k=%0d actual=%h expected=%h", req, op, a, k, res_y, expv);
    end
  endtask

  task automatic sweep_op(input string req, input logic [2:0] op);
    for (int a = 0; a < (1 << WIDTH); a++)
      for (int k = 0; k < WIDTH; k++)
        apply_check(req, op, WIDTH'(a), k, model(op, WIDTH'(a), k));
  endtask

  task automatic test_idle();
    @(negedge clk);
    checks++;
    if (res_y !== '0) begin
      errors++;
      $display("FAIL R1 idle actual=%h expected=%h", res_y, {WIDTH{1'b0}});
    end
  endtask

  task automatic test_named_examples();
    apply_check("R1", 3'b000, 8'b1011_0011, 1, 8'b0110_0110);
    apply_check("R2", 3'b001, 8'b1011_0011, 1, 8'b0101_1001);
    apply_check("R3", 3'b010, 8'b1011_0011, 3, 8'b1001_1000);
    apply_check("R4", 3'b011, 8'b1000_0000, 7, 8'b1111_1111);
    apply_check("R4", 3'b011, 8'b0111_1111, 7, 8'b0000_0000);
    apply_check("R5", 3'b100, 8'b1000_0001, 1, 8'b0000_0011);
    apply_check("R6", 3'b101, 8'b1000_0001, 1, 8'b1100_0000);
    apply_check("R6", 3'b101, 8'b0000_0001, 7, 8'b0000_0010);
  endtask

  task automatic test_zero_amount();
    for (int op = 0; op < 8; op++) begin
      apply_check("R7", 3'(op), 8'hA5, 0, 8'hA5);
      apply_check("R7", 3'(op), 8'h81, 0, 8'h81);
    end
  endtask

  task automatic test_unused_codes();
    for (int k = 0; k < WIDTH; k++) begin
      apply_check("R8", 3'b110, 8'h5C, k, 8'h5C);
      apply_check("R8", 3'b111, 8'hE3, k, 8'hE3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_idle();
    test_named_examples();
    sweep_op("R1", 3'b000);
    sweep_op("R2", 3'b001);
    sweep_op("R3", 3'b010);
    sweep_op("R4", 3'b011);
    sweep_op("R5", 3'b100);
    sweep_op("R6", 3'b101);
    test_zero_amount();
    test_unused_codes();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule